// File: doc/BRIEF.md
# Secure-Clear Watchdog Timer

This block is a watchdog timer that counts down from a programmed reload value and emits a one-cycle reset pulse when the count runs out before software services it. Software services it by writing to a clear port. In plain mode any such write reloads the counter. In secure mode the write only counts when its low byte equals the expected value held in an internal 8-bit linear feedback shift register. A write that does not match fires the reset at once, whatever count is left.

Software programs the block through a small write-only register port. While the watchdog is disabled, the control address sets the secure bit and can start the timer, the reload address sets the count, and the clear address loads the seed of the shift register. Once the timer is running, only the clear address has any effect. The shift register can never be read back, so software must track the sequence itself. The next state is the old state shifted left by one, XORed with 0x63 when the old bit 7 was 1. This is the polynomial x^8 + x^6 + x^5 + x + 1. From seed 0xAA the accepted values are 0xAA, 0x37, 0x6E, 0xDC, 0xDB and so on.

The controller has three states. IDLE is the disabled state. RUN is the counting state. FIRE lasts one cycle and asserts the reset. The transitions are start (IDLE to RUN on an enabling control write), good kick (RUN to RUN with a reload), bad kick (RUN to FIRE on a secure-mode mismatch), expiry (RUN to FIRE when the count is zero and no kick arrives), and rearm (FIRE to IDLE, which clears the counter and the shift register).

Top module: `wdt_secure`

## Requirements
- R1: After reset the block is disabled and `wdt_rst_o` stays low for as long as no enabling write occurs.
- R2: A write to address 0 with bit 0 set, made while disabled, loads the counter with the reload value (address 1, bits CNT_W-1:0). With reload value N and no kick, `wdt_rst_o` goes high in the (N+1)th cycle after the enabling write's clock edge.
- R3: `wdt_rst_o` is high for exactly one cycle. After it the block is disabled and produces no further pulse until it is enabled again.
- R4: With the secure bit (address 0 bit 1) clear, any write to address 2 while running reloads the counter with the reload value.
- R5: With the secure bit set, a write to address 2 whose bits 7:0 equal the expected value reloads the counter and advances the expected value to (v<<1) mod 256, XORed with 0x63 when bit 7 of v is 1.
- R6: With the secure bit set, a write to address 2 whose bits 7:0 differ from the expected value raises `wdt_rst_o` in the very next cycle, whatever count remains.
- R7: When the expected value is 0x00, every secure-mode write to address 2 fires the reset, including a write of 0x00.
- R8: A write to address 2 while disabled loads bits 7:0 as the new expected value (the seed).
- R9: While running, writes to address 0 and address 1 are ignored. They can neither stop the timer nor change the current expiry.
- R10: The pulse clears the expected value to 0x00, so enabling secure mode again without a new seed makes the first kick fire.
- R11: Writes to address 3 are ignored in every state.
- R12: A valid kick in the same cycle that the count reaches zero wins. The counter reloads and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 reload, 2 clear/seed, 3 unused |
| wr_data | input | DATA_W (16) | Write data |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
Some properties are checked by assertions on every cycle. A secure mismatch is always followed by a pulse, and the pulse never lasts more than one cycle before the block returns to IDLE. A good kick that coincides with a zero count never fires. Loads and decrements land in the counter, and advances, clears and seeds land in the shift register. Other behaviour can only be shown by the bench scenarios against its cycle-by-cycle model. These scenarios cover the exact expiry cycle for a given reload, the quoted 0xAA sequence and its mismatch, a seed of zero, the loss of the sequence after a pulse, and writes that the running timer must ignore.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_t;

    localparam int          ADDR_W      = 2;
    localparam logic [1:0]  ADDR_CTRL   = 2'd0;
    localparam logic [1:0]  ADDR_RELOAD = 2'd1;
    localparam logic [1:0]  ADDR_CLEAR  = 2'd2;

    localparam int          CTRL_EN_BIT  = 0;
    localparam int          CTRL_SEC_BIT = 1;

    localparam int          KEY_W    = 8;
    localparam logic [7:0]  KEY_TAPS = 8'h63;
endpackage

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              idle,
    output logic [CNT_W-1:0]  reload_q,
    output logic              secure_q,
    output logic              start,
    output logic              seed_wr,
    output logic [KEY_W-1:0]  seed_val,
    output logic              kick,
    output logic [KEY_W-1:0]  kick_val
);
    logic hit_ctrl, hit_reload, hit_clear;

    always_comb begin
        hit_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
        hit_reload = wr_en && (wr_addr == ADDR_RELOAD);
        hit_clear  = wr_en && (wr_addr == ADDR_CLEAR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            secure_q <= 1'b0;
        end else if (idle) begin
            if (hit_reload) reload_q <= wr_data[CNT_W-1:0];
            if (hit_ctrl)   secure_q <= wr_data[CTRL_SEC_BIT];
        end
    end

    always_comb begin
        start    = idle && hit_ctrl && wr_data[CTRL_EN_BIT];
        seed_wr  = idle && hit_clear;
        seed_val = wr_data[KEY_W-1:0];
        kick     = !idle && hit_clear;
        kick_val = wr_data[KEY_W-1:0];
    end
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] q,
    output logic             zero
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (clr)   q <= '0;
        else if (load)  q <= load_val;
        else if (dec)   q <= q - ONE;
    end

    assign zero = (q == '0);

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (q == $past(load_val)));

    // R2
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !clr && !zero) |=> (q == $past(q) - ONE));
endmodule

// File: rtl/wdt_lfsr.sv
`timescale 1ns/1ps
module wdt_lfsr #(
    parameter int               W    = 8,
    parameter logic [W-1:0]     TAPS = 8'h63
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         adv,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i == 0) begin : g_lsb
                assign nxt[i] = TAPS[i] & q[W-1];
            end else begin : g_up
                assign nxt[i] = q[i-1] ^ (TAPS[i] & q[W-1]);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (clr)   q <= '0;
        else if (load)  q <= load_val;
        else if (adv)   q <= nxt;
    end

    // R5
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && !load) |=>
            (q == (({$past(q[W-2:0]), 1'b0}) ^ ($past(q[W-1]) ? TAPS : '0))));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));

    // R8
    seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (q == $past(load_val)));
endmodule

// File: rtl/wdt_fsm.sv
`timescale 1ns/1ps
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             kick,
    input  logic [KEY_W-1:0] kick_val,
    input  logic [KEY_W-1:0] expect_val,
    input  logic             secure,
    input  logic             zero,
    output logic             idle,
    output logic             cnt_load,
    output logic             cnt_dec,
    output logic             cnt_clr,
    output logic             key_adv,
    output logic             key_clr,
    output logic             wd_rst
);
    wd_state_t st, nxt;
    logic      kick_ok;

    always_comb begin
        if (secure) kick_ok = (expect_val != '0) && (kick_val == expect_val);
        else        kick_ok = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= WD_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            WD_IDLE: if (start) nxt = WD_RUN;
            WD_RUN: begin
                if (kick)      nxt = kick_ok ? WD_RUN : WD_FIRE;
                else if (zero) nxt = WD_FIRE;
            end
            WD_FIRE: nxt = WD_IDLE;
            default: nxt = WD_IDLE;
        endcase
    end

    always_comb begin
        idle     = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_clr  = 1'b0;
        key_adv  = 1'b0;
        key_clr  = 1'b0;
        wd_rst   = 1'b0;
        unique case (st)
            WD_IDLE: begin
                idle     = 1'b1;
                cnt_load = start;
            end
            WD_RUN: begin
                cnt_load = kick && kick_ok;
                key_adv  = kick && kick_ok && secure;
                cnt_dec  = !kick && !zero;
            end
            WD_FIRE: begin
                wd_rst  = 1'b1;
                cnt_clr = 1'b1;
                key_clr = 1'b1;
            end
            default: idle = 1'b1;
        endcase
    end

    // R6
    mismatch_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_RUN && kick && secure && kick_val != expect_val) |=> wd_rst);

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |=> (!wd_rst && idle));

    // R12
    kick_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_RUN && kick && zero &&
         (!secure || (expect_val != '0 && kick_val == expect_val))) |=> !wd_rst);
endmodule

// File: rtl/wdt_secure.sv
`timescale 1ns/1ps
module wdt_secure
    import wdt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wdt_rst_o
);
    logic [CNT_W-1:0] reload_q, cnt_q;
    logic             secure_q, start, seed_wr, kick, idle, zero;
    logic [KEY_W-1:0] seed_val, kick_val, key_q;
    logic             cnt_load, cnt_dec, cnt_clr, key_adv, key_clr;

    wdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .idle(idle), .reload_q(reload_q),
        .secure_q(secure_q), .start(start), .seed_wr(seed_wr),
        .seed_val(seed_val), .kick(kick), .kick_val(kick_val)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .load(cnt_load),
        .load_val(reload_q), .dec(cnt_dec), .q(cnt_q), .zero(zero)
    );

    wdt_lfsr #(.W(KEY_W), .TAPS(KEY_TAPS)) u_key (
        .clk(clk), .rst_n(rst_n), .clr(key_clr), .load(seed_wr),
        .load_val(seed_val), .adv(key_adv), .q(key_q)
    );

    wdt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .kick(kick),
        .kick_val(kick_val), .expect_val(key_q), .secure(secure_q),
        .zero(zero), .idle(idle), .cnt_load(cnt_load), .cnt_dec(cnt_dec),
        .cnt_clr(cnt_clr), .key_adv(key_adv), .key_clr(key_clr),
        .wd_rst(wdt_rst_o)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !start) |=> !wdt_rst_o);
endmodule

// File: tb/sim_wdt_secure.sv
`timescale 1ns/1ps
module sim_wdt_secure;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        wdt_rst_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    wdt_secure u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wdt_rst_o(wdt_rst_o)
    );

    // behavioural reference: 0 off, 1 counting, 2 firing
    int m_mode = 0, m_cnt = 0, m_key = 0, m_reload = 0, m_sec = 0;

    function automatic int next_key(int v);
        int n;
        n = (v * 2) % 256;
        if (v >= 128) n = n ^ 'h63;
        return n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_key = 0; m_reload = 0; m_sec = 0;
        end else if (m_mode == 0) begin
            if (wr_en && wr_addr == 2'd0) begin
                m_sec = int'(wr_data[1]);
                if (wr_data[0]) begin m_mode = 1; m_cnt = m_reload; end
            end else if (wr_en && wr_addr == 2'd1) m_reload = int'(wr_data);
            else if (wr_en && wr_addr == 2'd2) m_key = int'(wr_data[7:0]);
        end else if (m_mode == 1) begin
            if (wr_en && wr_addr == 2'd2) begin
                if (m_sec == 0) m_cnt = m_reload;
                else if (m_key != 0 && int'(wr_data[7:0]) == m_key) begin
                    m_cnt = m_reload; m_key = next_key(m_key);
                end else m_mode = 2;
            end else if (m_cnt == 0) m_mode = 2;
            else m_cnt = m_cnt - 1;
        end else begin
            m_mode = 0; m_cnt = 0; m_key = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (wdt_rst_o !== (m_mode == 2)) begin
                errors++;
                $display("FAIL %s model compare: actual=%0b expected=%0b at %0t",
                         cur_req, wdt_rst_o, (m_mode == 2), $time);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called on a negedge; returns on the next negedge
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 2'd0; wr_data = 16'd0;
    endtask

    task automatic idle_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_pulse(input int maxn, output int at);
        at = -1;
        for (int i = 1; i <= maxn; i++) begin
            @(negedge clk);
            if (wdt_rst_o) begin at = i; break; end
        end
    endtask

    task automatic count_pulses(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wdt_rst_o) cnt++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int at, np;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R1";
        chk("R1 reset output", int'(wdt_rst_o), 0);
        count_pulses(20, np);
        chk("R1 no pulse while disabled", np, 0);

        cur_req = "R2";
        wr(2'd1, 16'd10);
        wr(2'd0, 16'h0001);
        wait_pulse(40, at);
        chk("R2 expiry cycle for reload 10", at, 11);

        cur_req = "R3";
        @(negedge clk);
        chk("R3 pulse one cycle", int'(wdt_rst_o), 0);
        count_pulses(30, np);
        chk("R3 stays disabled", np, 0);

        cur_req = "R4";
        wr(2'd0, 16'h0001);
        for (int k = 0; k < 6; k++) begin
            idle_n(4);
            wr(2'd2, 16'h0055);
        end
        chk("R4 no pulse with plain kicks", int'(wdt_rst_o), 0);
        wait_pulse(40, at);
        chk("R4 expiry after last kick", at, 11);
        @(negedge clk);

        cur_req = "R9";
        wr(2'd0, 16'h0001);
        idle_n(3);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd1000);
        wr(2'd0, 16'h0003);
        wait_pulse(40, at);
        chk("R9 running writes ignored", at, 5);
        @(negedge clk);
        wr(2'd0, 16'h0001);
        wait_pulse(40, at);
        chk("R9 reload unchanged", at, 11);
        @(negedge clk);

        cur_req = "R11";
        wr(2'd3, 16'd3);
        wr(2'd0, 16'h0001);
        wait_pulse(40, at);
        chk("R11 address 3 ignored", at, 11);
        @(negedge clk);

        cur_req = "R5";
        wr(2'd2, 16'h00AA);
        wr(2'd0, 16'h0003);
        idle_n(2); wr(2'd2, 16'h00AA);
        chk("R5/R8 seed accepted", int'(wdt_rst_o), 0);
        idle_n(2); wr(2'd2, 16'h0037);
        chk("R5 second value 0x37", int'(wdt_rst_o), 0);
        idle_n(2); wr(2'd2, 16'h006E);
        chk("R5 third value 0x6E", int'(wdt_rst_o), 0);
        idle_n(2); wr(2'd2, 16'h00DC);
        chk("R5 fourth value 0xDC", int'(wdt_rst_o), 0);
        idle_n(2); wr(2'd2, 16'h00DB);
        chk("R5 fifth value 0xDB", int'(wdt_rst_o), 0);
        cur_req = "R6";
        idle_n(2); wr(2'd2, 16'h0066);
        chk("R6 mismatch fires at once", int'(wdt_rst_o), 1);
        @(negedge clk);

        wr(2'd2, 16'h00AA);
        wr(2'd0, 16'h0003);
        wr(2'd2, 16'h00AA);
        wr(2'd2, 16'h0037);
        wr(2'd2, 16'h006E);
        chk("R6 no pulse before bad kick", int'(wdt_rst_o), 0);
        wr(2'd2, 16'h0066);
        chk("R6 0x66 where 0xDC expected", int'(wdt_rst_o), 1);
        @(negedge clk);

        cur_req = "R7";
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h0003);
        idle_n(2);
        wr(2'd2, 16'h0000);
        chk("R7 zero key fires", int'(wdt_rst_o), 1);
        @(negedge clk);

        cur_req = "R10";
        wr(2'd2, 16'h00AA);
        wr(2'd0, 16'h0003);
        wr(2'd2, 16'h0011);
        chk("R10 bad kick fires", int'(wdt_rst_o), 1);
        @(negedge clk);
        wr(2'd0, 16'h0003);
        wr(2'd2, 16'h00AA);
        chk("R10 key cleared by pulse", int'(wdt_rst_o), 1);
        @(negedge clk);

        cur_req = "R12";
        wr(2'd1, 16'd3);
        wr(2'd0, 16'h0001);
        idle_n(3);
        wr(2'd2, 16'h0000);
        chk("R12 kick at zero count wins", int'(wdt_rst_o), 0);
        wait_pulse(20, at);
        chk("R12 later expiry", at, 4);
        @(negedge clk);

        cur_req = "R8";
        wr(2'd2, 16'h0081);
        wr(2'd0, 16'h0003);
        wr(2'd2, 16'h0081);
        wr(2'd2, 16'h0061);
        chk("R8 seed 0x81 sequence", int'(wdt_rst_o), 0);
        wait_pulse(20, at);
        chk("R8 expiry in secure mode", at, 4);
        idle_n(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule